// File: doc/BRIEF.md
# Compare-Point Watchdog Channel

This block is one watchdog channel inside a bank of timer registers. A free-running up-counter advances by one on every cycle in which the tick enable is high, but only while both run bits of its control register are set. A compare register holds the point at which the watchdog expires. Software services the watchdog by reading the live count, adding its timeout interval and writing the sum back to the compare register. The sum may wrap past zero.

Expiry needs two things. The counter must be running, and a separate global arm register must hold 1. When a tick finds the count equal to the compare point under those conditions, the block raises a reset request. The request stays high until the next system reset.

Registers are reached over a plain strobe bus. A write takes effect on the clock edge where `reg_wr` is high. A read strobe returns its data one cycle later, flagged by `reg_rvalid`. The response cannot be back-pressured, so a consumer must take read data on the cycle it is flagged. The counter width is a parameter with a default of 32 bits. Data is always carried on a 32-bit bus, zero-extended.

Top module: `wdt_match_channel`

## Requirements
- R1: After reset the count, compare value, run bits and arm bit are 0, and `wdt_rst_req` is 0.
- R2: While control bits 0 and 1 are both 1, each cycle with `tick` high adds one to the count. The all-ones value is followed by 0.
- R3: When either control bit is 0, the count holds its value, whatever `tick` does.
- R4: The register offsets are fixed: control at 0x14 (run bits [1:0]), compare at 0x2C, live count at 0x5C, and arm at 0x64 (bit 0). A read strobe yields `reg_rvalid` and the data on the next cycle. The data shows the register contents as they were on the strobe cycle.
- R5: A write to any other offset is ignored, and a read from any other offset returns 0. A write to the count offset does not change the count.
- R6: A tick with the counter running, arm set and count equal to the compare value raises `wdt_rst_req` on the following cycle.
- R7: Once raised, `wdt_rst_req` stays high until `rst_n` is asserted, even if the channel is disarmed or stopped.
- R8: While arm is 0 or the counter is stopped, the count meeting the compare value never raises `wdt_rst_req`.
- R9: Writing a new compare value, the kick, moves the expiry point. A compare value numerically below the count is reached after the counter wraps through zero.
- R10: The compare register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the timer clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset within the timer bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response, one cycle after reg_rd |
| wdt_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the channel with an 8-bit counter, so that a wrapped compare point can be reached within a short run. A design that used an ordered comparison or a subtraction with a borrow would then never fire, or would fire at once. The bench checks that the request stays low when the compare point is passed while disarmed or stopped. A design that compared without checking arm would reset a system that was never armed. It also checks that the request stays high after the channel is disarmed, because a non-sticky request would drop before the reset controller could act. Finally, it checks that a write to the count offset or to an undefined offset leaves every readable register unchanged, and that reads of holes return zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // One-hot register select produced by the address decoder
  typedef struct packed {
    logic ctrl;
    logic cmp;
    logic count;
    logic arm;
  } wdt_sel_t;

  localparam int unsigned REG_STRIDE = 4;
endpackage

// File: rtl/wdt_regdec.sv
module wdt_regdec
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CH_IDX     = 5,
  parameter int unsigned CTRL_BASE  = 'h00,
  parameter int unsigned CMP_BASE   = 'h18,
  parameter int unsigned COUNT_BASE = 'h48,
  parameter int unsigned ARM_OFS    = 'h64
) (
  input  logic [ADDR_W-1:0] addr,
  output wdt_sel_t          sel
);
  localparam int unsigned CTRL_A  = CTRL_BASE  + REG_STRIDE * CH_IDX;
  localparam int unsigned CMP_A   = CMP_BASE   + REG_STRIDE * CH_IDX;
  localparam int unsigned COUNT_A = COUNT_BASE + REG_STRIDE * CH_IDX;

  always_comb begin
    sel       = '0;
    sel.ctrl  = (addr == ADDR_W'(CTRL_A));
    sel.cmp   = (addr == ADDR_W'(CMP_A));
    sel.count = (addr == ADDR_W'(COUNT_A));
    sel.arm   = (addr == ADDR_W'(ARM_OFS));
  end

  // R4
  onehot_sel_chk: assert final ($onehot0(sel));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (tick && run) count <= count + 1'b1;
  end

  // R3
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> (count - $past(count)) == CNT_W'(1));
endmodule

// File: rtl/wdt_trip.sv
module wdt_trip #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             arm,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  output logic             rst_req
);
  logic hit;

  // Equality is wrap-safe: the counter passes every value once per lap
  assign hit = tick && run && arm && (count == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rst_req <= 1'b0;
    else if (hit) rst_req <= 1'b1;
  end

  // R7
  sticky_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R8
  no_trip_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && (!arm || !run)) |=> !rst_req);
endmodule

// File: rtl/wdt_match_channel.sv
module wdt_match_channel
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CH_IDX     = 5,
  parameter int unsigned CTRL_BASE  = 'h00,
  parameter int unsigned CMP_BASE   = 'h18,
  parameter int unsigned COUNT_BASE = 'h48,
  parameter int unsigned ARM_OFS    = 'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              wdt_rst_req
);
  localparam int unsigned RUN_BITS = 2;

  wdt_sel_t            sel;
  logic [RUN_BITS-1:0] ctrl_q;
  logic [CNT_W-1:0]    cmp_q;
  logic                arm_q;
  logic [CNT_W-1:0]    count;
  logic                run;
  logic [DATA_W-1:0]   rd_mux;

  wdt_regdec #(
    .ADDR_W(ADDR_W), .CH_IDX(CH_IDX), .CTRL_BASE(CTRL_BASE),
    .CMP_BASE(CMP_BASE), .COUNT_BASE(COUNT_BASE), .ARM_OFS(ARM_OFS)
  ) u_dec (
    .addr(reg_addr),
    .sel (sel)
  );

  assign run = &ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      arm_q  <= 1'b0;
    end else if (reg_wr) begin
      if (sel.ctrl) ctrl_q <= reg_wdata[RUN_BITS-1:0];
      if (sel.cmp)  cmp_q  <= reg_wdata[CNT_W-1:0];
      if (sel.arm)  arm_q  <= reg_wdata[0];
    end
  end

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .run  (run),
    .count(count)
  );

  wdt_trip #(.CNT_W(CNT_W)) u_trip (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (run),
    .arm    (arm_q),
    .count  (count),
    .cmp    (cmp_q),
    .rst_req(wdt_rst_req)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel.ctrl:  rd_mux = DATA_W'(ctrl_q);
      sel.cmp:   rd_mux = DATA_W'(cmp_q);
      sel.count: rd_mux = DATA_W'(count);
      sel.arm:   rd_mux = DATA_W'(arm_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  // R4
  read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R6
  trip_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && arm_q && count == cmp_q) |=> wdt_rst_req);

  // R10
  cmp_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && sel.cmp) |=> $stable(cmp_q));
endmodule

// File: tb/tb_wdt_match_channel.sv
module tb_wdt_match_channel;
  localparam int CW = 8;
  localparam int CMASK = (1 << CW) - 1;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, wdt_rst_req;

  int checks = 0, errors = 0;
  bit tick_on = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_match_channel #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .wdt_rst_req(wdt_rst_req)
  );

  // Behavioural reference state
  int m_cnt, m_cmp, m_ctrl, m_arm, m_req, m_rdata, m_rvld;

  function automatic int model_read(input int a);
    case (a)
      'h14: return m_ctrl;
      'h2C: return m_cmp;
      'h5C: return m_cnt;
      'h64: return m_arm;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_ctrl = 0; m_arm = 0; m_req = 0; m_rdata = 0; m_rvld = 0;
    end else begin
      int rd_v;
      bit run;
      rd_v = model_read(reg_addr);
      run  = (m_ctrl == 3);
      m_rvld = reg_rd;
      if (reg_rd) m_rdata = rd_v;
      if (tick && run && m_arm == 1 && m_cnt == m_cmp) m_req = 1;
      if (tick && run) m_cnt = (m_cnt + 1) & CMASK;
      if (reg_wr) begin
        case (reg_addr)
          'h14: m_ctrl = reg_wdata & 3;
          'h2C: m_cmp  = reg_wdata & CMASK;
          'h64: m_arm  = reg_wdata & 1;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(wdt_rst_req == m_req[0], "R6", wdt_rst_req, m_req);
      check(reg_rvalid == m_rvld[0], "R4", reg_rvalid, m_rvld);
      if (reg_rvalid) check(reg_rdata == m_rdata, "R4", reg_rdata, m_rdata);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      tick = tick_on && !tick;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a[7:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a[7:0];
    @(negedge clk);
    reg_rd = 0; reg_addr = 0;
    d = reg_rdata;
  endtask

  int v, v2;

  initial begin
    // R1 reset state
    idle(3);
    check(wdt_rst_req == 0, "R1", wdt_rst_req, 0);
    rst_n = 1;
    idle(2);
    rd('h5C, v);  check(v == 0, "R1", v, 0);
    rd('h64, v);  check(v == 0, "R1", v, 0);
    rd('h14, v);  check(v == 0, "R1", v, 0);
    tick_on = 1;

    // R3 stopped: init write of zero, then only one run bit
    wr('h14, 0);
    idle(10);
    rd('h5C, v);  check(v == 0, "R3", v, 0);
    wr('h14, 1);
    idle(10);
    rd('h5C, v);  check(v == 0, "R3", v, 0);

    // R2 running
    wr('h14, 3);
    idle(20);
    rd('h5C, v);  check(v != 0, "R2", v, m_cnt);

    // R5 holes and read-only count
    wr('h10, 'h5A);
    rd('h10, v);  check(v == 0, "R5", v, 0);
    wr('h60, 1);
    rd('h64, v);  check(v == 0, "R5", v, 0);
    wr('h5C, 'h00);
    rd('h5C, v);  check(v == m_rdata && v != 0, "R5", v, m_rdata);

    // R10 compare readback
    wr('h2C, 'hAB);
    rd('h2C, v);  check(v == 'hAB, "R10", v, 'hAB);

    // R8 passing the compare point while disarmed
    rd('h5C, v);
    wr('h2C, (v + 4) & CMASK);
    idle(30);
    check(wdt_rst_req == 0, "R8", wdt_rst_req, 0);

    // R8 armed but stopped at the compare point
    wr('h14, 2);
    rd('h5C, v);
    wr('h2C, v);
    wr('h64, 1);
    idle(20);
    check(wdt_rst_req == 0, "R8", wdt_rst_req, 0);
    rd('h5C, v2); check(v2 == v, "R3", v2, v);

    // R9 regular kicks keep it quiet
    wr('h64, 0);
    wr('h14, 3);
    wr('h64, 1);
    for (int k = 0; k < 6; k++) begin
      rd('h5C, v);
      wr('h2C, (v + 30) & CMASK);
      idle(20);
    end
    check(wdt_rst_req == 0, "R9", wdt_rst_req, 0);

    // R9 wrapped compare point, then expiry (R6)
    rd('h5C, v);
    wr('h2C, (v + 240) & CMASK);
    rd('h2C, v2); check(v2 < v, "R9", v2, v);
    idle(420);
    check(wdt_rst_req == 0, "R9", wdt_rst_req, 0);
    idle(120);
    check(wdt_rst_req == 1, "R6", wdt_rst_req, 1);

    // R7 sticky through disarm and stop
    wr('h64, 0);
    wr('h14, 0);
    idle(10);
    check(wdt_rst_req == 1, "R7", wdt_rst_req, 1);

    // R1 reset clears it
    @(negedge clk);
    rst_n = 0;
    idle(2);
    check(wdt_rst_req == 0, "R1", wdt_rst_req, 0);
    rst_n = 1;
    idle(2);
    rd('h2C, v);  check(v == 0, "R1", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule